// File: doc/BRIEF.md
# Asynchronous Static Memory Access Sequencer

This block turns single host requests into timed asynchronous read and write cycles on an external static device, such as an SRAM, a pseudo-static RAM or a NOR flash. The devices share one address bus, one data bus and the strobes, and each device has its own chip select. The host places a request with address, write data, byte enables, chip-select index and direction. The block then steps through a fixed series of phases. Each phase length is a count of system clock cycles taken from configuration inputs. When the access is done, the block pulses an acknowledge, and for a read it also presents the captured data.

An access may first assert the byte lanes for a lead time. It then asserts chip select and moves through address setup, an address hold (only when address and data share the bus), data setup and data hold. A turnaround gap must pass before the next access. Reads use one set of phase lengths. Writes use a second set when that set is enabled. A wait input can stretch data setup, and its active level can be chosen. The data bus is split into an output, an output enable and an input, so the tri-state pad stays outside the block. The data width is 8 or 16 bits, and the chip-select count is a parameter.

The host keeps `reqValid` and the request fields steady until it sees `ack`. It drops `reqValid` in the following cycle unless another request is ready. Configuration must not change while an access is running.

Top module: `asyncMemSeq`

## Requirements
- R1: While `rstN` is low and just after it is released, every `memCsN` bit, `memOeN`, `memWeN` and every `memBeN` bit are 1, and `memDataOe` and `ack` are 0.
- R2: A read accepted in cycle c begins in cycle c+1 when the block is free. It runs lead, address setup, data setup and data hold phases in that order, each lasting its programmed number of cycles. `memOeN` is 0 exactly during data setup, and `memDataOe` is never 1 while `memOeN` is 0.
- R3: A phase programmed with 0 takes no cycles. Data setup programmed with 0 lasts one cycle.
- R4: For a read, the value on `memDataIn` in the last cycle of data setup appears on `rdData` by the cycle in which `ack` is 1. Values in earlier or later cycles have no effect.
- R5: `ack` is 1 for exactly one cycle, the cycle right after the last cycle of the access, and is 0 in every other cycle.
- R6: If an access ends in cycle E with a turnaround of T cycles, the next access has its first active cycle no earlier than E+2+max(T,1). It starts exactly then if a request is already waiting.
- R7: With `cfgMuxEn`=1, the address hold phase follows address setup. Through address setup and address hold, `memDataOe` is 1 and `memDataOut` carries the low data-width bits of the address. With `cfgMuxEn`=0, the address hold value is ignored and takes no cycles.
- R8: For a write, `memWeN` is 0 exactly during data setup. `memDataOe` is 1 and `memDataOut` equals the write data throughout data setup and data hold.
- R9: With `cfgWrSetEn`=1, writes use the write-set lengths for address setup, address hold, data setup, data hold and turnaround. Reads, and writes made while `cfgWrSetEn`=0, use the read set.
- R10: With `cfgWaitEn`=1, each data setup cycle in which `memWait` equals `cfgWaitHigh` adds one cycle to data setup. With `cfgWaitEn`=0, `memWait` has no effect on any output.
- R11: For every lane j with `reqBe[j]`=1, `memBeN[j]` is 0 from the first lead cycle to the last data hold cycle. Lead cycles come before chip select goes low, and lanes with `reqBe[j]`=0 stay at 1.
- R12: Only `memCsN[reqCs]` goes low during an access, and at most one chip select is low in any cycle. `memAddr` holds the request address while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqCs | input | CS_W | Index of the target chip select |
| reqAddr | input | ADDR_W | Access address |
| reqWdata | input | DATA_W | Write data |
| reqBe | input | LANES | Byte-lane enables, 1 = lane used |
| ack | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Last captured read data |
| cfgLead | input | CNT_W | Lane lead cycles before chip select |
| cfgAddrSetup | input | CNT_W | Read-set address setup cycles |
| cfgAddrHold | input | CNT_W | Read-set address hold cycles (multiplexed mode) |
| cfgDataSetup | input | CNT_W | Read-set data setup cycles |
| cfgDataHold | input | CNT_W | Read-set data hold cycles |
| cfgTurn | input | CNT_W | Read-set turnaround cycles |
| cfgWrSetEn | input | 1 | Writes use the write set |
| cfgWrAddrSetup | input | CNT_W | Write-set address setup cycles |
| cfgWrAddrHold | input | CNT_W | Write-set address hold cycles |
| cfgWrDataSetup | input | CNT_W | Write-set data setup cycles |
| cfgWrDataHold | input | CNT_W | Write-set data hold cycles |
| cfgWrTurn | input | CNT_W | Write-set turnaround cycles |
| cfgMuxEn | input | 1 | Address driven on the data bus first |
| cfgWaitHigh | input | 1 | Wait is active at level 1 |
| cfgWaitEn | input | 1 | Wait input stretches data setup |
| memCsN | output | NUM_CS | Chip selects, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memBeN | output | LANES | Byte-lane enables, active low |
| memAddr | output | ADDR_W | Device address |
| memDataOut | output | DATA_W | Data bus value to drive |
| memDataOe | output | 1 | Drive enable for the data bus |
| memDataIn | input | DATA_W | Data bus value read back |
| memWait | input | 1 | Device wait request |

## Verification
The bench builds the block with a 16-bit data bus (two byte lanes), four chip selects, a 20-bit address and 4-bit phase fields. With these values it can test single-lane enables, chip selects other than index 0, and phase lengths up to 15 cycles. A behavioural model in the bench derives every phase boundary from the programmed lengths. It compares all strobes, the driven bus value and the acknowledge on every clock. The stimulus covers zero-length phases, back-to-back requests under several turnaround values, both bus modes, both timing sets, and wait stretching at each polarity and while disabled.

// File: rtl/asmPkg.sv
package asmPkg;

  // Phase order matters: the sequencer walks upward through these codes.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_ASET  = 3'd2,
    PH_AHOLD = 3'd3,
    PH_DSET  = 3'd4,
    PH_DHOLD = 3'd5,
    PH_TURN  = 3'd6
  } phase_e;

  localparam int NUM_PH = 7;

  // Strobes from control to datapath.
  typedef struct packed {
    logic take;       // latch a new request
    logic capture;    // sample read data
    logic laneOn;     // byte lanes active
    logic selOn;      // chip select active
    logic rdStrobe;   // output enable active
    logic wrStrobe;   // write enable active
    logic addrOnBus;  // address driven on data bus
    logic dataOnBus;  // write data driven on data bus
  } strobe_t;

endpackage

// File: rtl/asmTimingSel.sv
module asmTimingSel #(
  parameter int CNT_W = 4
) (
  input  logic                              selWrite,
  input  logic                              cfgWrSetEn,
  input  logic                              cfgMuxEn,
  input  logic [CNT_W-1:0]                  cfgLead,
  input  logic [CNT_W-1:0]                  cfgAddrSetup,
  input  logic [CNT_W-1:0]                  cfgAddrHold,
  input  logic [CNT_W-1:0]                  cfgDataSetup,
  input  logic [CNT_W-1:0]                  cfgDataHold,
  input  logic [CNT_W-1:0]                  cfgTurn,
  input  logic [CNT_W-1:0]                  cfgWrAddrSetup,
  input  logic [CNT_W-1:0]                  cfgWrAddrHold,
  input  logic [CNT_W-1:0]                  cfgWrDataSetup,
  input  logic [CNT_W-1:0]                  cfgWrDataHold,
  input  logic [CNT_W-1:0]                  cfgWrTurn,
  output logic [asmPkg::NUM_PH-1:0][CNT_W-1:0] phDur
);
  import asmPkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             useWr;
  logic [CNT_W-1:0] aSet, aHold, dSet, dHold, turn;

  assign useWr = selWrite & cfgWrSetEn;
  assign aSet  = useWr ? cfgWrAddrSetup : cfgAddrSetup;
  assign aHold = useWr ? cfgWrAddrHold  : cfgAddrHold;
  assign dSet  = useWr ? cfgWrDataSetup : cfgDataSetup;
  assign dHold = useWr ? cfgWrDataHold  : cfgDataHold;
  assign turn  = useWr ? cfgWrTurn      : cfgTurn;

  always_comb begin
    phDur           = '0;
    phDur[PH_LEAD]  = cfgLead;
    phDur[PH_ASET]  = aSet;
    phDur[PH_AHOLD] = cfgMuxEn ? aHold : '0;
    phDur[PH_DSET]  = (dSet == '0) ? ONE : dSet;
    phDur[PH_DHOLD] = dHold;
    phDur[PH_TURN]  = turn;
  end

endmodule

// File: rtl/asmSeqCtrl.sv
module asmSeqCtrl #(
  parameter int CNT_W = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 reqValid,
  input  logic                                 reqWrite,
  input  logic                                 memWait,
  input  logic                                 cfgWaitHigh,
  input  logic                                 cfgWaitEn,
  input  logic                                 cfgMuxEn,
  input  logic [asmPkg::NUM_PH-1:0][CNT_W-1:0] phDur,
  output logic                                 selWrite,
  output asmPkg::strobe_t                      strobes,
  output logic                                 ack
);
  import asmPkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e           phase, succ;
  logic [CNT_W-1:0] cnt;
  logic             wrQ, ackQ;
  logic             waitAct, stall, start, done, endAcc;

  assign selWrite = (phase == PH_IDLE) ? reqWrite : wrQ;
  assign waitAct  = cfgWaitEn && (memWait == cfgWaitHigh);
  assign stall    = (phase == PH_DSET) && waitAct;
  assign start    = (phase == PH_IDLE) && reqValid && !ackQ;
  assign done     = (phase != PH_IDLE) && (cnt == '0) && !stall;
  assign endAcc   = done && ((phase == PH_DSET) || (phase == PH_DHOLD)) &&
                    ((succ == PH_TURN) || (succ == PH_IDLE));

  // Nearest later phase with a non-zero length; idle when none remains.
  always_comb begin
    succ = PH_IDLE;
    for (int k = NUM_PH - 1; k >= 1; k--) begin
      if ((k > int'(phase)) && (phDur[k] != '0)) succ = phase_e'(3'(k));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      wrQ   <= 1'b0;
      ackQ  <= 1'b0;
    end else begin
      ackQ <= endAcc;
      if (start) begin
        phase <= succ;
        cnt   <= phDur[succ] - ONE;
        wrQ   <= reqWrite;
      end else if (done) begin
        phase <= succ;
        cnt   <= (succ == PH_IDLE) ? '0 : phDur[succ] - ONE;
      end else if ((phase != PH_IDLE) && !stall) begin
        cnt <= cnt - ONE;
      end
    end
  end

  always_comb begin
    strobes.take      = start;
    strobes.capture   = done && (phase == PH_DSET) && !wrQ;
    strobes.laneOn    = (phase != PH_IDLE) && (phase != PH_TURN);
    strobes.selOn     = (phase == PH_ASET) || (phase == PH_AHOLD) ||
                        (phase == PH_DSET) || (phase == PH_DHOLD);
    strobes.rdStrobe  = (phase == PH_DSET) && !wrQ;
    strobes.wrStrobe  = (phase == PH_DSET) && wrQ;
    strobes.addrOnBus = cfgMuxEn && ((phase == PH_ASET) || (phase == PH_AHOLD));
    strobes.dataOnBus = wrQ && ((phase == PH_DSET) || (phase == PH_DHOLD));
  end

  assign ack = ackQ;

  // R5: acknowledge never lasts two cycles
  p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |=> !ackQ);

  // R6: after an acknowledge the sequencer is in turnaround or idle, never a new access
  p_ack_then_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |=> ((phase == PH_TURN) || (phase == PH_IDLE)));

  // R10: an active wait keeps the data setup phase in place
  p_wait_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> ((phase == PH_DSET) && $stable(cnt)));

endmodule

// File: rtl/asmSeqDpath.sv
module asmSeqDpath #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int NUM_CS = 4,
  parameter int LANES  = DATA_W / 8,
  parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  asmPkg::strobe_t   strobes,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqBe,
  input  logic [DATA_W-1:0] memDataIn,
  output logic [NUM_CS-1:0] memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [LANES-1:0]  memBeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  output logic [DATA_W-1:0] rdData
);
  logic [CS_W-1:0]   csQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdQ;
  logic [LANES-1:0]  beQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ    <= '0;
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      rdQ    <= '0;
    end else begin
      if (strobes.take) begin
        csQ    <= reqCs;
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        beQ    <= reqBe;
      end
      if (strobes.capture) rdQ <= memDataIn;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign memCsN[i] = !(strobes.selOn && (csQ == CS_W'(i)));
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign memBeN[j] = !(strobes.laneOn && beQ[j]);
  end

  assign memOeN     = !strobes.rdStrobe;
  assign memWeN     = !strobes.wrStrobe;
  assign memAddr    = addrQ;
  assign memDataOut = strobes.addrOnBus ? addrQ[DATA_W-1:0] : wdataQ;
  assign memDataOe  = strobes.addrOnBus || strobes.dataOnBus;
  assign rdData     = rdQ;

  // R12: at most one device selected
  p_one_select_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN));

  // R2: the block never drives the bus while the device is told to drive it
  p_no_contention_r2: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDataOe);

  // R8: read and write strobes are never active together
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

endmodule

// File: rtl/asyncMemSeq.sv
module asyncMemSeq #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 4,
  localparam int LANES = DATA_W / 8,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqBe,
  output logic              ack,
  output logic [DATA_W-1:0] rdData,
  input  logic [CNT_W-1:0]  cfgLead,
  input  logic [CNT_W-1:0]  cfgAddrSetup,
  input  logic [CNT_W-1:0]  cfgAddrHold,
  input  logic [CNT_W-1:0]  cfgDataSetup,
  input  logic [CNT_W-1:0]  cfgDataHold,
  input  logic [CNT_W-1:0]  cfgTurn,
  input  logic              cfgWrSetEn,
  input  logic [CNT_W-1:0]  cfgWrAddrSetup,
  input  logic [CNT_W-1:0]  cfgWrAddrHold,
  input  logic [CNT_W-1:0]  cfgWrDataSetup,
  input  logic [CNT_W-1:0]  cfgWrDataHold,
  input  logic [CNT_W-1:0]  cfgWrTurn,
  input  logic              cfgMuxEn,
  input  logic              cfgWaitHigh,
  input  logic              cfgWaitEn,
  output logic [NUM_CS-1:0] memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [LANES-1:0]  memBeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  input  logic [DATA_W-1:0] memDataIn,
  input  logic              memWait
);
  import asmPkg::*;

  logic                            selWrite;
  logic [NUM_PH-1:0][CNT_W-1:0]    phDur;
  strobe_t                         strobes;

  asmTimingSel #(.CNT_W(CNT_W)) uTiming (
    .selWrite       (selWrite),
    .cfgWrSetEn     (cfgWrSetEn),
    .cfgMuxEn       (cfgMuxEn),
    .cfgLead        (cfgLead),
    .cfgAddrSetup   (cfgAddrSetup),
    .cfgAddrHold    (cfgAddrHold),
    .cfgDataSetup   (cfgDataSetup),
    .cfgDataHold    (cfgDataHold),
    .cfgTurn        (cfgTurn),
    .cfgWrAddrSetup (cfgWrAddrSetup),
    .cfgWrAddrHold  (cfgWrAddrHold),
    .cfgWrDataSetup (cfgWrDataSetup),
    .cfgWrDataHold  (cfgWrDataHold),
    .cfgWrTurn      (cfgWrTurn),
    .phDur          (phDur)
  );

  asmSeqCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .memWait     (memWait),
    .cfgWaitHigh (cfgWaitHigh),
    .cfgWaitEn   (cfgWaitEn),
    .cfgMuxEn    (cfgMuxEn),
    .phDur       (phDur),
    .selWrite    (selWrite),
    .strobes     (strobes),
    .ack         (ack)
  );

  asmSeqDpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_CS (NUM_CS),
    .LANES  (LANES),
    .CS_W   (CS_W)
  ) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqCs      (reqCs),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .reqBe      (reqBe),
    .memDataIn  (memDataIn),
    .memCsN     (memCsN),
    .memOeN     (memOeN),
    .memWeN     (memWeN),
    .memBeN     (memBeN),
    .memAddr    (memAddr),
    .memDataOut (memDataOut),
    .memDataOe  (memDataOe),
    .rdData     (rdData)
  );

endmodule

// File: tb/sim_asyncMemSeq.sv
`timescale 1ns/1ps
module sim_asyncMemSeq;
  localparam int AW = 20, DW = 16, NCS = 4, CW = 4, LN = 2, CSW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0;
  logic [CSW-1:0] reqCs = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [LN-1:0] reqBe = '0;
  logic ack;
  logic [DW-1:0] rdData;
  logic [CW-1:0] cfgLead = 0, cfgAddrSetup = 0, cfgAddrHold = 0, cfgDataSetup = 1,
                 cfgDataHold = 0, cfgTurn = 0;
  logic cfgWrSetEn = 0;
  logic [CW-1:0] cfgWrAddrSetup = 0, cfgWrAddrHold = 0, cfgWrDataSetup = 1,
                 cfgWrDataHold = 0, cfgWrTurn = 0;
  logic cfgMuxEn = 0, cfgWaitHigh = 0, cfgWaitEn = 0;
  logic [NCS-1:0] memCsN;
  logic memOeN, memWeN, memDataOe;
  logic [LN-1:0] memBeN;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memDataOut;
  logic [DW-1:0] memDataIn = '0;
  logic memWait = 1'b1;

  asyncMemSeq #(.ADDR_W(AW), .DATA_W(DW), .NUM_CS(NCS), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqCs(reqCs),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .ack(ack), .rdData(rdData),
    .cfgLead(cfgLead), .cfgAddrSetup(cfgAddrSetup), .cfgAddrHold(cfgAddrHold),
    .cfgDataSetup(cfgDataSetup), .cfgDataHold(cfgDataHold), .cfgTurn(cfgTurn),
    .cfgWrSetEn(cfgWrSetEn), .cfgWrAddrSetup(cfgWrAddrSetup), .cfgWrAddrHold(cfgWrAddrHold),
    .cfgWrDataSetup(cfgWrDataSetup), .cfgWrDataHold(cfgWrDataHold), .cfgWrTurn(cfgWrTurn),
    .cfgMuxEn(cfgMuxEn), .cfgWaitHigh(cfgWaitHigh), .cfgWaitEn(cfgWaitEn),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN), .memBeN(memBeN),
    .memAddr(memAddr), .memDataOut(memDataOut), .memDataOe(memDataOe),
    .memDataIn(memDataIn), .memWait(memWait));

  int nChk = 0, nFail = 0, cyc = 0, earliest = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: run hung at cycle %0d, got running expected finished", cyc);
      summary();
      $finish;
    end
  end

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  function automatic logic [9:0] pins();
    return {memCsN, memOeN, memWeN, memBeN, memDataOe, ack};
  endfunction

  localparam logic [9:0] IDLE_PINS = {4'hF, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0};

  function automatic logic waitLvl(bit active);
    return active ? cfgWaitHigh : !cfgWaitHigh;
  endfunction

  task automatic idleFor(string tag, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp(tag, "idle pins", 64'(pins()), 64'(IDLE_PINS));
    end
  endtask

  // Behavioural model of one access; called at a negedge, returns at the ack cycle's negedge.
  task automatic doAccess(string tag, bit wr, logic [AW-1:0] a, logic [DW-1:0] wd,
                          logic [LN-1:0] be, int cs, int waitN, logic [DW-1:0] rv);
    bit ws = wr && cfgWrSetEn;
    int lead = cfgLead;
    int aSet = ws ? cfgWrAddrSetup : cfgAddrSetup;
    int aHld = cfgMuxEn ? (ws ? cfgWrAddrHold : cfgAddrHold) : 0;
    int dSet = ws ? cfgWrDataSetup : cfgDataSetup;
    int dHld = ws ? cfgWrDataHold : cfgDataHold;
    int trn  = ws ? cfgWrTurn : cfgTurn;
    int c = cyc;
    int s, aS, hS, dS, hhS, e;
    if (dSet == 0) dSet = 1;
    if (cfgWaitEn) dSet += waitN;
    s   = (c + 1 > earliest) ? c + 1 : earliest;
    aS  = s + lead;
    hS  = aS + aSet;
    dS  = hS + aHld;
    hhS = dS + dSet;
    e   = hhS + dHld - 1;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = wd; reqBe = be;
    reqCs = CSW'(cs);
    for (int k = c + 1; k <= e + 1; k++) begin
      logic [NCS-1:0] eCs;
      logic [LN-1:0] eBe;
      logic eOe, eWe, eDoe;
      @(negedge clk);
      eCs = '1;
      if (k >= aS && k <= e) eCs[cs] = 1'b0;
      eBe  = (k >= s && k <= e) ? ~be : '1;
      eOe  = !(!wr && k >= dS && k < hhS);
      eWe  = !(wr && k >= dS && k < hhS);
      eDoe = (cfgMuxEn && k >= aS && k < dS) || (wr && k >= dS && k <= e);
      cmp(tag, "pins", 64'(pins()), 64'({eCs, eOe, eWe, eBe, eDoe, (k == e + 1)}));
      if (eDoe)
        cmp(tag, "bus value", 64'(memDataOut), 64'((k < dS) ? a[DW-1:0] : wd));
      if (k >= aS && k <= e) cmp(tag, "address", 64'(memAddr), 64'(a));
      if (k == e + 1) begin
        if (!wr) cmp(tag, "R4 read data", 64'(rdData), 64'(rv));
        reqValid = 0;
      end
      memWait   = waitLvl(k >= dS && k < dS + waitN);
      memDataIn = (k == hhS - 1) ? rv : (rv ^ DW'(16'h5A00 + k));
    end
    earliest = e + 2 + ((trn > 1) ? trn : 1);
  endtask

  task automatic setRd(int l, int as, int ah, int ds, int dh, int t);
    cfgLead = CW'(l); cfgAddrSetup = CW'(as); cfgAddrHold = CW'(ah);
    cfgDataSetup = CW'(ds); cfgDataHold = CW'(dh); cfgTurn = CW'(t);
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      cmp("R1", "reset pins", 64'(pins()), 64'(IDLE_PINS));
    end
    rstN = 1'b1;
    idleFor("R1", 2);

    // R2: plain read phase sequence
    setRd(0, 2, 0, 3, 1, 0);
    doAccess("R2", 0, 20'h12345, 16'h0, 2'b11, 0, 0, 16'hBEEF);
    idleFor("R6", 3);

    // R11 and R12: lane lead, single lane, other chip select
    setRd(2, 1, 0, 2, 2, 1);
    doAccess("R11/R12", 0, 20'hABCDE, 16'h0, 2'b01, 2, 0, 16'h1234);
    idleFor("R6", 3);
    doAccess("R12", 0, 20'h00F0F, 16'h0, 2'b10, 3, 0, 16'h4321);
    idleFor("R6", 3);

    // R3: zero-length phases; data setup zero lasts one cycle; R4 capture
    setRd(0, 0, 0, 0, 0, 0);
    doAccess("R3/R4", 0, 20'h00011, 16'h0, 2'b11, 1, 0, 16'hC001);
    // R6: back-to-back requests under several turnarounds
    doAccess("R6", 0, 20'h00022, 16'h0, 2'b11, 1, 0, 16'hC002);
    setRd(0, 1, 0, 4, 1, 1);
    doAccess("R6/R4", 0, 20'h00033, 16'h0, 2'b11, 0, 0, 16'hC003);
    doAccess("R6", 0, 20'h00044, 16'h0, 2'b11, 0, 0, 16'hC004);
    setRd(1, 1, 0, 1, 0, 4);
    doAccess("R6", 0, 20'h00055, 16'h0, 2'b11, 0, 0, 16'hC005);
    doAccess("R6/R5", 0, 20'h00066, 16'h0, 2'b11, 0, 0, 16'hC006);
    idleFor("R5", 6);

    // R7: address hold ignored in non-multiplexed mode, then multiplexed mode
    setRd(0, 1, 3, 2, 0, 0);
    doAccess("R7", 0, 20'h77777, 16'h0, 2'b11, 0, 0, 16'h7070);
    idleFor("R7", 2);
    cfgMuxEn = 1;
    doAccess("R7", 0, 20'h9A5C3, 16'h0, 2'b11, 1, 0, 16'h7171);
    idleFor("R7", 2);
    cfgMuxEn = 0;

    // R8: write using the read set (write set disabled)
    cfgWrAddrSetup = 5; cfgWrDataSetup = 6; cfgWrTurn = 5;
    setRd(1, 2, 0, 2, 2, 0);
    doAccess("R8/R9", 1, 20'h01234, 16'hD00D, 2'b11, 2, 0, 16'h0);
    idleFor("R8", 3);

    // R9: write set enabled; a read right after still uses the read set
    cfgWrSetEn = 1; cfgWrAddrHold = 2; cfgWrDataHold = 1; cfgWrTurn = 3;
    doAccess("R9", 1, 20'h05678, 16'hFACE, 2'b10, 1, 0, 16'h0);
    doAccess("R9", 0, 20'h09ABC, 16'h0, 2'b11, 1, 0, 16'h5150);
    cfgMuxEn = 1;
    doAccess("R9/R7", 1, 20'h0CAFE, 16'h600D, 2'b11, 3, 0, 16'h0);
    idleFor("R9", 2);
    cfgMuxEn = 0; cfgWrSetEn = 0;

    // R10: wait stretching at both polarities, and ignored when disabled
    setRd(0, 1, 0, 2, 1, 0);
    cfgWaitEn = 1; cfgWaitHigh = 0; memWait = 1'b1;
    doAccess("R10", 0, 20'h0A0A0, 16'h0, 2'b11, 0, 3, 16'hAAAA);
    idleFor("R10", 2);
    cfgWaitHigh = 1; memWait = 1'b0;
    doAccess("R10", 1, 20'h0B0B0, 16'h3C3C, 2'b11, 0, 2, 16'h0);
    idleFor("R10", 2);
    cfgWaitEn = 0;
    doAccess("R10", 0, 20'h0C0C0, 16'h0, 2'b11, 0, 4, 16'hBBBB);
    idleFor("R10", 4);

    finished = 1;
    summary();
    $finish;
  end

endmodule